// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called side A and side B. Every pad is split into a separate input, output and output-enable, so the block contains no tri-state logic. Each side has its own capture register, loaded from that side's bus when the matching capture strobe rises. Each forwarding path, A to B and B to A, sends either the live value from the far bus or the value held in the register captured from it. An active-low enable and a direction input decide which of the two sides drives its pads, if either does.

Both capture strobes can be asynchronous to the block. Each passes through a synchronizer chain into the system clock domain, and only its rising edge causes a load. Capture runs whatever the enable and direction inputs are set to. A register can therefore be filled while the buses are isolated, or while its own bus is being driven.

Top module: `regbus_xcvr`

## Requirements
- R1: A high `rst` at a rising clock edge clears both capture registers to zero and clears the strobe synchronizers. While `rst` is high, both output-enables are low.
- R2: After `cap_a` goes high, the A register takes the value of `a_in` present at the (SYNC_STAGES+1)-th rising clock edge at which `cap_a` is sampled high, which is the third edge with the default SYNC_STAGES=2.
- R3: `cap_b` loads the B register from `b_in` with the same timing as R2.
- R4: A strobe held high causes only one load. A register keeps its value on every edge without a fresh rising strobe edge.
- R5: `b_out` equals `a_in` when `sel_a2b` is 0 and the A register when `sel_a2b` is 1.
- R6: `a_out` equals `b_in` when `sel_b2a` is 0 and the B register when `sel_b2a` is 1.
- R7: With `en_n` low, `dir` = 0 asserts only `a_oe` and `dir` = 1 asserts only `b_oe`.
- R8: With `en_n` high, neither output-enable is asserted, and both registers still capture on their strobes.
- R9: Capture does not depend on `en_n` or `dir`. This includes loading a side's register while that same side is being driven.
- R10: When a select input changes, the output takes the new source's value in that same cycle, with no intermediate value. This also holds when a load happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Value sensed on side A pads |
| a_out | output | WIDTH | Value offered to side A pads |
| a_oe | output | 1 | Drive enable for side A pads |
| b_in | input | WIDTH | Value sensed on side B pads |
| b_out | output | WIDTH | Value offered to side B pads |
| b_oe | output | 1 | Drive enable for side B pads |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| sel_a2b | input | 1 | B-side source: 0 live A, 1 stored A |
| sel_b2a | input | 1 | A-side source: 0 live B, 1 stored B |
| en_n | input | 1 | Active-low drive enable |
| dir | input | 1 | 0 drives side A, 1 drives side B |

## Verification
A synchronized strobe edge that loads a register can arrive in the same cycle as a change of the select that routes that register to the far bus. In that cycle the output has to show the freshly loaded value, not the old one and not the live bus. The bench provokes this with a directed sequence that flips `sel_a2b` exactly in the load cycle. Random runs flip the selects and strobes independently every cycle, so the collision also occurs by chance. Each output is compared with a bench model of the strobe pipeline and the two registers.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
   typedef enum logic {DRIVE_A = 1'b0, DRIVE_B = 1'b1} drive_side_e;
   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/regbus_strobe_edge.sv
module regbus_strobe_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   output logic load_o
);
   import regbus_xcvr_pkg::*;
   localparam int MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("regbus_strobe_edge: SYNC_STAGES below minimum");
   end

   logic [MSB:0] chain_q;
   logic         prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[MSB-1:0], strobe_i};
         prev_q  <= chain_q[MSB];
      end
   end

   assign load_o = chain_q[MSB] & ~prev_q;

   // R4: a load pulse never lasts more than one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      load_o |=> !load_o);
endmodule

// File: rtl/regbus_capture_reg.sv
module regbus_capture_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("regbus_capture_reg: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)         q_o <= '0;
      else if (load_i) q_o <= d_i;
   end

   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (q_o == '0));
   a_r2_load_takes_bus: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (q_o == $past(d_i)));
   a_r4_hold_without_load: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(q_o));
endmodule

// File: rtl/regbus_path_sel.sv
module regbus_path_sel #(
   parameter int WIDTH = 8
) (
   input  logic             sel_stored_i,
   input  logic [WIDTH-1:0] live_i,
   input  logic [WIDTH-1:0] stored_i,
   output logic [WIDTH-1:0] out_o
);
   // One-level selection: each bit is a single 2:1 choice, so no
   // intermediate value exists between the two sources.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign out_o[i] = sel_stored_i ? stored_i[i] : live_i[i];
   end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe,
   input  logic             cap_a,
   input  logic             cap_b,
   input  logic             sel_a2b,
   input  logic             sel_b2a,
   input  logic             en_n,
   input  logic             dir
);
   import regbus_xcvr_pkg::*;

   logic             load_a, load_b;
   logic [WIDTH-1:0] reg_a, reg_b;
   drive_side_e      side;

   regbus_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_a (
      .clk(clk), .rst(rst), .strobe_i(cap_a), .load_o(load_a));
   regbus_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_b (
      .clk(clk), .rst(rst), .strobe_i(cap_b), .load_o(load_b));

   regbus_capture_reg #(.WIDTH(WIDTH)) u_reg_a (
      .clk(clk), .rst(rst), .load_i(load_a), .d_i(a_in), .q_o(reg_a));
   regbus_capture_reg #(.WIDTH(WIDTH)) u_reg_b (
      .clk(clk), .rst(rst), .load_i(load_b), .d_i(b_in), .q_o(reg_b));

   regbus_path_sel #(.WIDTH(WIDTH)) u_sel_a2b (
      .sel_stored_i(sel_a2b), .live_i(a_in), .stored_i(reg_a), .out_o(b_out));
   regbus_path_sel #(.WIDTH(WIDTH)) u_sel_b2a (
      .sel_stored_i(sel_b2a), .live_i(b_in), .stored_i(reg_b), .out_o(a_out));

   assign side = drive_side_e'(dir);

   always_comb begin
      a_oe = 1'b0;
      b_oe = 1'b0;
      if (!rst && !en_n) begin
         if (side == DRIVE_A) a_oe = 1'b1;
         else                 b_oe = 1'b1;
      end
   end

   a_r7_at_most_one_driver: assert property (@(posedge clk)
      $countones({a_oe, b_oe}) <= 1);
   a_r8_isolated_when_disabled: assert property (@(posedge clk) disable iff (rst)
      en_n |-> !a_oe && !b_oe);
   a_r7_enabled_drives_one: assert property (@(posedge clk) disable iff (rst)
      !en_n |-> $onehot0({a_oe, b_oe}) && (a_oe || b_oe));
endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb_top;
   localparam int  WIDTH  = 8;
   localparam int  SYNC   = 2;
   localparam time PERIOD = 10;

   logic             clk = 1'b0;
   logic             rst;
   logic [WIDTH-1:0] a_in, b_in, a_out, b_out;
   logic             a_oe, b_oe, cap_a, cap_b, sel_a2b, sel_b2a, en_n, dir;

   regbus_xcvr #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_a(cap_a), .cap_b(cap_b),
      .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .en_n(en_n), .dir(dir));

   always #(PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit done   = 0;
   string phase = "R5";

   logic [WIDTH-1:0] m_ra, m_rb;
   logic [SYNC-1:0]  m_sa, m_sb;
   logic             m_pa, m_pb;

   function automatic logic [WIDTH-1:0] exp_path(logic sel, logic [WIDTH-1:0] live,
                                                logic [WIDTH-1:0] stored);
      return sel ? stored : live;
   endfunction

   function automatic logic exp_oe(logic r, logic en, logic d, logic want_b);
      return !r && !en && (d == want_b);
   endfunction

   task automatic chk(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s/%s act=%h exp=%h", tag, phase, act, exp);
      end
   endtask

   task automatic step();
      logic la, lb;
      @(posedge clk);
      if (rst) begin
         m_ra = '0; m_rb = '0; m_sa = '0; m_sb = '0; m_pa = 0; m_pb = 0;
      end else begin
         la = m_sa[SYNC-1] & ~m_pa;
         lb = m_sb[SYNC-1] & ~m_pb;
         if (la) m_ra = a_in;
         if (lb) m_rb = b_in;
         m_pa = m_sa[SYNC-1];
         m_pb = m_sb[SYNC-1];
         m_sa = {m_sa[SYNC-2:0], cap_a};
         m_sb = {m_sb[SYNC-2:0], cap_b};
      end
      #1;
      chk("R5", b_out, exp_path(sel_a2b, a_in, m_ra));
      chk("R6", a_out, exp_path(sel_b2a, b_in, m_rb));
      chk("R7", {7'd0, a_oe}, {7'd0, exp_oe(rst, en_n, dir, 1'b0)});
      chk("R8", {7'd0, b_oe}, {7'd0, exp_oe(rst, en_n, dir, 1'b1)});
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst = 1; a_in = 8'h3c; b_in = 8'hc3; cap_a = 0; cap_b = 0;
      sel_a2b = 1; sel_b2a = 1; en_n = 0; dir = 0;
      m_ra = 'x; m_rb = 'x; m_sa = '0; m_sb = '0; m_pa = 0; m_pb = 0;
      phase = "R1";
      step(); step();
      chk("R1", b_out, 8'h00);
      chk("R1", a_out, 8'h00);
      chk("R1", {6'd0, a_oe, b_oe}, 8'h00);
      rst = 0;
      step();

      // R2, R4, R9: capture A while side A is driven, strobe held high
      phase = "R9"; en_n = 0; dir = 0; sel_a2b = 1;
      cap_a = 1; a_in = 8'h11; step();
      a_in = 8'h22; step();
      a_in = 8'h5a; step();
      chk("R2", b_out, 8'h5a);
      phase = "R4";
      for (int i = 0; i < 6; i++) begin a_in = 8'(i * 37 + 1); step(); end
      chk("R4", b_out, 8'h5a);

      // R3, R8: capture B while both sides isolated
      phase = "R8"; en_n = 1; sel_b2a = 1; cap_b = 1;
      b_in = 8'h01; step(); b_in = 8'h02; step(); b_in = 8'ha7; step();
      chk("R3", a_out, 8'ha7);
      chk("R8", {6'd0, a_oe, b_oe}, 8'h00);

      // R10: select flips to stored in the same cycle the load lands
      phase = "R10"; en_n = 0; dir = 1; cap_a = 0; sel_a2b = 0; step(); step(); step();
      cap_a = 1; a_in = 8'h90; step(); step();
      a_in = 8'h6e; sel_a2b = 1; step();
      chk("R10", b_out, 8'h6e);
      sel_a2b = 0; a_in = 8'h0f; step();
      chk("R10", b_out, 8'h0f);

      // constrained random mix
      phase = "RND";
      for (int n = 0; n < 3000; n++) begin
         a_in    = 8'($urandom);
         b_in    = 8'($urandom);
         cap_a   = ($urandom % 4) == 0 ? ~cap_a : cap_a;
         cap_b   = ($urandom % 4) == 0 ? ~cap_b : cap_b;
         sel_a2b = 1'($urandom);
         sel_b2a = 1'($urandom);
         en_n    = ($urandom % 4) == 0;
         dir     = 1'($urandom);
         rst     = ($urandom % 500) == 0;
         step();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule